// File: doc/BRIEF.md
# Front-End Event Integrity Checker

This block sits between two front-end data streams and a processor. Each stream delivers events as 16-bit words on a 17-bit bus: the extra bit flags the closing word of an event. While an event streams through, the block checks it three ways. It verifies a CRC on every chip's data block and a CRC over the whole event. It also checks the word count against the length implied by the event type, which sets a number of samples and a number of gains.

Every word is forwarded to the processor side one cycle after it arrives. When the closing word arrives, the block raises a per-stream interrupt for one cycle and presents two sideband results:
- a 16-bit chip word, which folds the 32-bit chip mask in pairs and combines it with the per-block CRC results;
- a 3-bit error status.

Both sideband values stay stable until the stream's next event closes. The two streams are fully independent.

Top module: `fe_event_checker`

## Requirements
- R1: Each valid input word appears on `out_word` with `out_vld` high exactly one cycle later. Bit 16 of the input bus set marks the last word of an event. The first valid word after reset or after a last word is the header, whose bits [1:0] give the event type.
- R2: One cycle after a last word is accepted, that stream's `irq` pulses for one cycle, together with `out_vld` and `out_last`.
- R3: The expected word count, including header and last word, is 4 + 16 × (samples × gains + 1). The types map as follows: type 0 is 7 samples × 1 gain, type 1 is 7 × 2, type 2 is 3 × 1, and type 3 is 3 × 2. `chk_stat` bit 0 is set when the count differs.
- R4: The two mask words are followed by 16 chip blocks, chip 0 first. Each block is samples × gains data words followed by one CRC word. The block CRC is CRC-16 with polynomial 0x8005, initial value 0, no reflection, processing one 16-bit word per step, MSB first.
- R5: The last word carries the CRC (same algorithm) over every earlier word of the event, header included. `chk_stat` bit 1 is set when it does not match.
- R6: `chk_stat` bit 2 is set when any fully received block's CRC word mismatches, whatever the chip mask says.
- R7: The word after the header holds mask bits 31:16 and the next word holds bits 15:0. Chip c is present when mask bit 2c or bit 2c+1 is set. `chk_mask` bit c is 1 only when chip c is present, its block was fully received, and its CRC matched.
- R8: Reset clears `chk_mask`, `chk_stat`, `irq` and `out_vld`. `chk_mask` and `chk_stat` change only together with an `irq` pulse.
- R9: The two streams may carry events at the same time and close in the same cycle without affecting each other's results.
- R10: In a short event, chips whose blocks did not fully arrive report 0 in `chk_mask`. Extra words after the 16th block take part in no block check but do count towards the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 2 | Per-stream word valid |
| in_bus | input | 2×17 | Per-stream bus: bit 16 last-word flag, bits 15:0 data |
| out_vld | output | 2 | Per-stream forwarded word valid |
| out_word | output | 2×16 | Per-stream forwarded data word |
| out_last | output | 2 | Forwarded word is an event's last word |
| irq | output | 2 | Per-stream event-complete pulse |
| chk_mask | output | 2×16 | Compacted chip mask merged with block CRC results |
| chk_stat | output | 2×3 | Bit 2 block CRC error, bit 1 global CRC error, bit 0 length error |

## Verification
The hardest case to reach from the ports is an event that ends early but on a clean block boundary. In that case the global CRC is still valid, so only the length flag and the missing chip bits reveal the truncation. The stimulus builds such events by truncating after a chosen number of blocks (zero through fifteen) and recomputing the trailing CRC. It also appends a surplus word to full events, corrupts a single chosen block CRC, and drives both streams so that they close in the same cycle. Random gaps between words check that the results do not depend on idle cycles.

// File: rtl/fe_chk_pkg.sv
package fe_chk_pkg;

    localparam int WORD_W    = 16;
    localparam int BUS_W     = WORD_W + 1;
    localparam int NCHIP     = WORD_W;
    localparam int HDR_WORDS = 4;
    localparam int POS_W     = 9;
    localparam int SPG_W     = 4;
    localparam int TYPE_W    = 2;
    localparam int STAT_W    = 3;
    localparam logic [WORD_W-1:0] CRC_POLY = 16'h8005;

    typedef logic [TYPE_W-1:0] evt_type_t;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_MASK_HI,
        PH_MASK_LO,
        PH_BODY
    } phase_t;

    typedef struct packed {
        logic blk_bad;
        logic gcrc_bad;
        logic len_bad;
    } evt_stat_t;

    function automatic int samples_of(evt_type_t t);
        return t[1] ? 3 : 7;
    endfunction

    function automatic int gains_of(evt_type_t t);
        return t[0] ? 2 : 1;
    endfunction

    function automatic logic [SPG_W-1:0] spg_of(evt_type_t t);
        return SPG_W'(samples_of(t) * gains_of(t));
    endfunction

    function automatic logic [POS_W:0] exp_len_of(evt_type_t t);
        return (POS_W+1)'(HDR_WORDS + NCHIP * (samples_of(t) * gains_of(t) + 1));
    endfunction

endpackage

// File: rtl/crc16_word_step.sv
module crc16_word_step #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'h8005
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] acc;
    logic         fb;

    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            fb  = acc[W-1] ^ data_in[i];
            acc = {acc[W-2:0], 1'b0};
            if (fb) acc = acc ^ POLY;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/chip_mask_pack.sv
module chip_mask_pack #(
    parameter int NCH = 16
) (
    input  logic [2*NCH-1:0] wide_mask,
    output logic [NCH-1:0]   narrow_mask
);
    for (genvar c = 0; c < NCH; c++) begin : g_pair
        assign narrow_mask[c] = wide_mask[2*c] | wide_mask[2*c+1];
    end
endmodule

// File: rtl/fe_stream_check.sv
module fe_stream_check
    import fe_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [BUS_W-1:0]  in_bus,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_word,
    output logic              out_last,
    output logic              irq,
    output logic [NCHIP-1:0]  chk_mask,
    output logic [STAT_W-1:0] chk_stat
);
    localparam int IDX_W = $clog2(NCHIP);
    localparam logic [IDX_W:0] NBLK = (IDX_W+1)'(NCHIP);

    phase_t              phase;
    logic [POS_W-1:0]    pos;
    evt_type_t           typ;
    logic [WORD_W-1:0]   m_hi, m_lo;
    logic [IDX_W:0]      blk_idx;
    logic [SPG_W-1:0]    blk_word;
    logic [WORD_W-1:0]   bcrc, gcrc, bcrc_nx, gcrc_nx;
    logic [NCHIP-1:0]    bad, present, ok_bits;

    logic [WORD_W-1:0]   w;
    logic                w_last;
    logic [SPG_W-1:0]    spg;
    logic [POS_W:0]      exp_len, len_now;
    logic                in_blocks, blk_end;
    evt_stat_t           stat_nx;

    assign w         = in_bus[WORD_W-1:0];
    assign w_last    = in_bus[WORD_W];
    assign spg       = spg_of(typ);
    assign exp_len   = exp_len_of(typ);
    assign len_now   = {1'b0, pos} + (POS_W+1)'(1);
    assign in_blocks = (phase == PH_BODY) && (blk_idx < NBLK);
    assign blk_end   = (blk_word == spg);

    crc16_word_step #(.W(WORD_W), .POLY(CRC_POLY)) u_blk_crc (
        .crc_in (bcrc),
        .data_in(w),
        .crc_out(bcrc_nx)
    );

    crc16_word_step #(.W(WORD_W), .POLY(CRC_POLY)) u_evt_crc (
        .crc_in (gcrc),
        .data_in(w),
        .crc_out(gcrc_nx)
    );

    chip_mask_pack #(.NCH(NCHIP)) u_pack (
        .wide_mask  ({m_hi, m_lo}),
        .narrow_mask(present)
    );

    for (genvar c = 0; c < NCHIP; c++) begin : g_ok
        localparam logic [IDX_W:0] CI = (IDX_W+1)'(c);
        assign ok_bits[c] = (blk_idx > CI) & ~bad[c];
    end

    assign stat_nx = '{blk_bad:  |bad,
                       gcrc_bad: (w != gcrc),
                       len_bad:  (len_now != exp_len)};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_word <= '0;
            out_last <= 1'b0;
            irq      <= 1'b0;
            chk_mask <= '0;
            chk_stat <= '0;
            phase    <= PH_HDR;
            pos      <= '0;
            typ      <= '0;
            m_hi     <= '0;
            m_lo     <= '0;
            blk_idx  <= '0;
            blk_word <= '0;
            bcrc     <= '0;
            gcrc     <= '0;
            bad      <= '0;
        end else begin
            out_vld  <= in_vld;
            out_word <= w;
            out_last <= in_vld & w_last;
            irq      <= in_vld & w_last;
            if (in_vld) begin
                if (w_last) begin
                    chk_stat <= stat_nx;
                    chk_mask <= present & ok_bits;
                    phase    <= PH_HDR;
                    pos      <= '0;
                    typ      <= '0;
                    m_hi     <= '0;
                    m_lo     <= '0;
                    blk_idx  <= '0;
                    blk_word <= '0;
                    bcrc     <= '0;
                    gcrc     <= '0;
                    bad      <= '0;
                end else begin
                    gcrc <= gcrc_nx;
                    if (pos != '1) pos <= pos + 1'b1;
                    unique case (phase)
                        PH_HDR: begin
                            typ   <= w[TYPE_W-1:0];
                            phase <= PH_MASK_HI;
                        end
                        PH_MASK_HI: begin
                            m_hi  <= w;
                            phase <= PH_MASK_LO;
                        end
                        PH_MASK_LO: begin
                            m_lo  <= w;
                            phase <= PH_BODY;
                        end
                        PH_BODY: begin
                            if (in_blocks) begin
                                if (blk_end) begin
                                    if (w != bcrc) bad[blk_idx[IDX_W-1:0]] <= 1'b1;
                                    bcrc     <= '0;
                                    blk_word <= '0;
                                    blk_idx  <= blk_idx + 1'b1;
                                end else begin
                                    bcrc     <= bcrc_nx;
                                    blk_word <= blk_word + 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/fe_event_checker.sv
module fe_event_checker
    import fe_chk_pkg::*;
#(
    parameter int NSTREAM = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NSTREAM-1:0]               in_vld,
    input  logic [NSTREAM-1:0][BUS_W-1:0]    in_bus,
    output logic [NSTREAM-1:0]               out_vld,
    output logic [NSTREAM-1:0][WORD_W-1:0]   out_word,
    output logic [NSTREAM-1:0]               out_last,
    output logic [NSTREAM-1:0]               irq,
    output logic [NSTREAM-1:0][NCHIP-1:0]    chk_mask,
    output logic [NSTREAM-1:0][STAT_W-1:0]   chk_stat
);
    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        fe_stream_check u_str (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (in_vld[s]),
            .in_bus  (in_bus[s]),
            .out_vld (out_vld[s]),
            .out_word(out_word[s]),
            .out_last(out_last[s]),
            .irq     (irq[s]),
            .chk_mask(chk_mask[s]),
            .chk_stat(chk_stat[s])
        );
    end
endmodule

// File: rtl/fe_event_checker_sva.sv
module fe_event_checker_sva
    import fe_chk_pkg::*;
#(
    parameter int NSTREAM = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NSTREAM-1:0]               in_vld,
    input logic [NSTREAM-1:0][BUS_W-1:0]    in_bus,
    input logic [NSTREAM-1:0]               out_vld,
    input logic [NSTREAM-1:0][WORD_W-1:0]   out_word,
    input logic [NSTREAM-1:0]               out_last,
    input logic [NSTREAM-1:0]               irq,
    input logic [NSTREAM-1:0][NCHIP-1:0]    chk_mask,
    input logic [NSTREAM-1:0][STAT_W-1:0]   chk_stat
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    for (genvar s = 0; s < NSTREAM; s++) begin : g_chk
        assert_fwd_valid_R1: assert property (@(posedge clk) disable iff (rst || !past_ok)
            out_vld[s] == $past(in_vld[s]));

        assert_fwd_word_R1: assert property (@(posedge clk) disable iff (rst || !past_ok)
            $past(in_vld[s]) |-> out_word[s] == $past(in_bus[s][WORD_W-1:0]));

        assert_irq_timing_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
            irq[s] == $past(in_vld[s] & in_bus[s][WORD_W]));

        assert_irq_closing_R2: assert property (@(posedge clk) disable iff (rst)
            irq[s] |-> (out_vld[s] && out_last[s]));

        assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
            !irq[s] |-> ($stable(chk_mask[s]) && $stable(chk_stat[s])));
    end
endmodule

bind fe_event_checker fe_event_checker_sva #(.NSTREAM(NSTREAM)) u_sva (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_bus  (in_bus),
    .out_vld (out_vld),
    .out_word(out_word),
    .out_last(out_last),
    .irq     (irq),
    .chk_mask(chk_mask),
    .chk_stat(chk_stat)
);

// File: tb/test_fe_event_checker.sv
module test_fe_event_checker;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tb_vld [2];
    logic [16:0]       tb_bus [2];
    logic [1:0]        in_vld;
    logic [1:0][16:0]  in_bus;
    logic [1:0]        out_vld, out_last, irq;
    logic [1:0][15:0]  out_word, chk_mask;
    logic [1:0][2:0]   chk_stat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [16:0] ev [2][300];
    int          ev_len [2];
    logic [15:0] exp_mask [2];
    logic [2:0]  exp_stat [2];
    logic [15:0] prev_mask [2];
    logic [2:0]  prev_stat [2];

    assign in_vld = {tb_vld[1], tb_vld[0]};
    assign in_bus = {tb_bus[1], tb_bus[0]};

    always #2 clk = ~clk;

    fe_event_checker i_fe_event_checker (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_bus(in_bus),
        .out_vld(out_vld), .out_word(out_word), .out_last(out_last),
        .irq(irq), .chk_mask(chk_mask), .chk_stat(chk_stat)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(logic [15:0] c, logic [15:0] d);
        logic [15:0] r = c;
        for (int i = 15; i >= 0; i--) begin
            logic fb = r[15] ^ d[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    // mode 0 clean, 1 bad block CRC at chip arg, 2 bad global CRC,
    // 3 only arg blocks sent, 4 one surplus word after the last block
    task automatic build(input int s, input logic [1:0] t, input logic [31:0] m,
                         input int mode, input int arg);
        int n, spg, nblk;
        logic [15:0] b, g, d;
        spg = (t[1] ? 3 : 7) * (t[0] ? 2 : 1);
        n = 0;
        ev[s][n] = {1'b0, 14'($urandom), t}; n++;
        ev[s][n] = {1'b0, m[31:16]};        n++;
        ev[s][n] = {1'b0, m[15:0]};         n++;
        nblk = (mode == 3) ? arg : 16;
        for (int c = 0; c < nblk; c++) begin
            b = 16'h0;
            for (int i = 0; i < spg; i++) begin
                d = 16'($urandom);
                ev[s][n] = {1'b0, d}; n++;
                b = crc_step(b, d);
            end
            if (mode == 1 && c == arg) b = b ^ 16'h0001;
            ev[s][n] = {1'b0, b}; n++;
        end
        if (mode == 4) begin
            ev[s][n] = {1'b0, 16'($urandom)}; n++;
        end
        g = 16'h0;
        for (int i = 0; i < n; i++) g = crc_step(g, ev[s][i][15:0]);
        if (mode == 2) g = g ^ 16'h8000;
        ev[s][n] = {1'b1, g}; n++;
        ev_len[s] = n;
        for (int c = 0; c < 16; c++)
            exp_mask[s][c] = (m[2*c] | m[2*c+1]) && (c < nblk) && !(mode == 1 && c == arg);
        exp_stat[s] = {mode == 1, mode == 2, (mode == 3 || mode == 4)};
    endtask

    task automatic send(input int s, input bit gaps, input string tag);
        int werr = 0;
        for (int i = 0; i < ev_len[s]; i++) begin
            tb_vld[s] = 1'b1;
            tb_bus[s] = ev[s][i];
            @(negedge clk);
            if (!out_vld[s] || out_word[s] !== ev[s][i][15:0]) werr++;
            if (i == 5) begin
                chk(chk_mask[s] == prev_mask[s], "R8", "mask held mid-event", chk_mask[s], prev_mask[s]);
                chk(chk_stat[s] == prev_stat[s], "R8", "status held mid-event", chk_stat[s], prev_stat[s]);
            end
            if (gaps && i + 1 < ev_len[s] && ($urandom % 4 == 0)) begin
                tb_vld[s] = 1'b0;
                @(negedge clk);
            end
        end
        tb_vld[s] = 1'b0;
        chk(werr == 0, "R1", "forwarded word mismatches", werr, 0);
        chk(irq[s] && out_last[s], "R2", "irq with closing word", {irq[s], out_last[s]}, 2'b11);
        chk(chk_mask[s] == exp_mask[s], tag, "R4 R7 chip result word", chk_mask[s], exp_mask[s]);
        chk(chk_stat[s][0] == exp_stat[s][0], "R3", "length flag", chk_stat[s][0], exp_stat[s][0]);
        chk(chk_stat[s][1] == exp_stat[s][1], "R5", "global CRC flag", chk_stat[s][1], exp_stat[s][1]);
        chk(chk_stat[s][2] == exp_stat[s][2], "R6", "block CRC flag", chk_stat[s][2], exp_stat[s][2]);
        prev_mask[s] = exp_mask[s];
        prev_stat[s] = exp_stat[s];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        tb_vld[0] = 1'b0; tb_vld[1] = 1'b0;
        tb_bus[0] = '0;   tb_bus[1] = '0;
        prev_mask[0] = '0; prev_mask[1] = '0;
        prev_stat[0] = '0; prev_stat[1] = '0;
        repeat (3) @(negedge clk);
        chk(out_vld == 2'b00 && irq == 2'b00, "R8", "reset valid/irq", {out_vld, irq}, 0);
        chk(chk_mask == '0 && chk_stat == '0, "R8", "reset results", {chk_mask, chk_stat}, 0);
        rst = 1'b0;
        @(negedge clk);

        build(0, 2'd0, 32'hFFFF_FFFF, 0, 0);  send(0, 1'b0, "R7");
        build(0, 2'd2, 32'h0000_0000, 0, 0);  send(0, 1'b0, "R7");
        build(1, 2'd1, 32'h5555_5555, 1, 15); send(1, 1'b0, "R7");
        build(1, 2'd3, 32'hA0A0_0003, 1, 0);  send(1, 1'b1, "R7");
        // R10: truncated after zero blocks and after fifteen blocks
        build(0, 2'd2, 32'hFFFF_FFFF, 3, 0);  send(0, 1'b0, "R10");
        build(0, 2'd3, 32'hFFFF_FFFF, 3, 15); send(0, 1'b0, "R10");
        // R10: surplus word after the last block
        build(1, 2'd2, 32'hFFFF_FFFF, 4, 0);  send(1, 1'b0, "R10");
        build(1, 2'd0, 32'h1234_8001, 2, 0);  send(1, 1'b1, "R7");
        // R9: both streams close in the same cycle
        build(0, 2'd2, 32'hFFFF_0000, 1, 3);
        build(1, 2'd2, 32'h0000_FFFF, 0, 0);
        fork
            send(0, 1'b0, "R9");
            send(1, 1'b0, "R9");
        join

        for (int k = 0; k < 24; k++) begin
            int mode0 = $urandom % 5;
            int mode1 = $urandom % 5;
            logic [31:0] mk0 = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            logic [31:0] mk1 = $urandom;
            build(0, 2'($urandom), mk0, mode0, $urandom % 16);
            build(1, 2'($urandom), mk1, mode1, $urandom % 16);
            if (k % 2 == 0) begin
                fork
                    send(0, 1'($urandom), "R9");
                    send(1, 1'($urandom), "R9");
                join
            end else begin
                send(0, 1'($urandom), "R7");
                send(1, 1'b0, "R7");
            end
        end

        repeat (3) @(negedge clk);
        chk(chk_mask[0] == prev_mask[0] && chk_stat[0] == prev_stat[0], "R8",
            "results held while idle", {chk_mask[0], chk_stat[0]}, {prev_mask[0], prev_stat[0]});
        finish_run();
    end

endmodule